// File: doc/BRIEF.md
# Driver Fault Filter and Latch

This block sits between the analog fault comparators of a multi-channel power driver and the output stages. For each of the driver switches it receives a raw overcurrent flag and a raw open-load flag. For the whole chip it receives raw flags for supply overvoltage, supply undervoltage, temperature warning and thermal shutdown. A flag counts as real only after it has stayed high, without a break, for a set number of timebase ticks. Each kind of flag has its own tick count. Once a flag qualifies, it sets a sticky status bit, and only the clear strobe from the serial interface resets that bit.

The block also produces one enable bit per driver. An overcurrent turns off its own channel. A thermal shutdown turns off every channel. A supply fault also turns off every channel, and it releases them in one of two ways. With the lockout input low, the drivers come back as soon as the supply flag drops. With lockout high, they stay off until software clears the status bits. Open load and temperature warning are only reported and never change an enable.

Top module: `drv_fault_guard`

## Requirements
- R1: An overcurrent status bit is set only after its raw flag has stayed high for OC_TICKS timebase ticks and then one more clock edge. Channel k (0-based) appears at bit k+1 of `stat_oc`.
- R2: An open-load status bit is set only after its raw flag has stayed high for OL_TICKS ticks and then one more clock edge. Channel k appears at bit k+1 of `stat_ol`.
- R3: If a raw flag drops before it qualifies, its tick count returns to zero, and the next assertion of that flag must again last the full interval.
- R4: Bit 0 of `stat_oc` and bit 0 of `stat_ol` always read 0.
- R5: A set overcurrent bit drives the enable of that channel low and leaves every other channel enabled. The channel stays off after its raw flag falls, until `clr` is pulsed.
- R6: Open-load bits and the temperature warning flag do not change `drv_en`.
- R7: The thermal shutdown flag is set after TSD_TICKS ticks plus one clock edge. All enables stay low while that flag is set. They also stay low while the raw thermal flag is still high after the flag has qualified. Re-enabling needs both the flag cleared and the raw flag low.
- R8: With `lockout` low, an overvoltage or undervoltage flag held for SUP_TICKS ticks drives all enables low. The enables return in the cycle the raw flag drops, with no clear. The matching status flag is set one edge after qualification and stays set.
- R9: With `lockout` high, all enables stay low while `ov_flag` or `uv_flag` is set, even after the supply flag drops. A `clr` pulse restores them.
- R10: A `clr` pulse zeroes every status bit on the next edge and restarts every tick count. If a raw flag is still high, its bit sets again only after a fresh full interval.
- R11: Tick counts advance only on clock edges where `tick` is high. Setting a status bit does not need a tick.
- R12: After reset, all status bits and flags are 0 and all enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase tick that advances the qualification counters |
| oc_raw | input | NUM_CH | Raw overcurrent comparator flags, one per channel |
| ol_raw | input | NUM_CH | Raw open-load comparator flags, one per channel |
| ov_raw | input | 1 | Raw supply overvoltage flag |
| uv_raw | input | 1 | Raw supply undervoltage flag |
| tw_raw | input | 1 | Raw temperature warning flag |
| tsd_raw | input | 1 | Raw thermal shutdown flag (low once below the hysteresis point) |
| lockout | input | 1 | 1: a supply fault keeps the drivers off until cleared |
| clr | input | 1 | Clears all status bits and restarts the counters |
| stat_oc | output | NUM_CH+1 | Overcurrent status word; channels at bits 1..NUM_CH, bit 0 reads 0 |
| stat_ol | output | NUM_CH+1 | Open-load status word; channels at bits 1..NUM_CH, bit 0 reads 0 |
| tw_flag | output | 1 | Latched temperature warning |
| tsd_flag | output | 1 | Latched thermal shutdown |
| ov_flag | output | 1 | Latched supply overvoltage |
| uv_flag | output | 1 | Latched supply undervoltage |
| drv_en | output | NUM_CH | Per-channel driver enable |

## Verification
A counter that is wrong, or that fails to clear, shows up at the ports as a status bit that sets one or more edges too early or too late against the required tick count. The bench sweeps the hold length across each threshold, so it catches such an error within that one fault episode. A sticky bit or a shutdown hold in the wrong state shows up as an enable that is wrong in the very cycle that follows: an enable restored before a clear, or left low after the raw flag drops. Each of these shows up on `drv_en` or in the status words at the edge where the fault appears, ends, or is cleared.

// File: rtl/dfg_pkg.sv
// Shared types for the driver fault filter and latch.
package dfg_pkg;

    // Chip-level fault flags, raw or latched.
    typedef struct packed {
        logic ov;
        logic uv;
        logic tw;
        logic tsd;
    } chip_flags_t;

endpackage

// File: rtl/dfg_qual_filter.sv
// Minimum-duration qualifier for one raw fault flag.
// Counts timebase ticks while the raw flag stays high and saturates at
// THRESH. A low raw flag or a restart request sets the count back to zero.
// qual is high while the raw flag is high and the count has reached THRESH.
// Assumes THRESH >= 1.
module dfg_qual_filter #(
    parameter int unsigned THRESH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic restart,
    output logic qual
);
    localparam int unsigned CW = (THRESH < 2) ? 1 : $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt;

    // Saturating tick counter, zeroed on a raw drop or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !raw) begin
            cnt <= '0;
        end else if (tick && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = raw && (cnt == LIMIT);
endmodule

// File: rtl/dfg_chan_bank.sv
// One bank of per-channel fault qualifiers with sticky status bits.
// Each channel has its own filter. A qualified channel sets its status bit,
// and the bit holds until clr. Assumes clr is a synchronous strobe.
module dfg_chan_bank #(
    parameter int unsigned NUM_CH = 11,
    parameter int unsigned THRESH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] raw,
    input  logic              clr,
    output logic [NUM_CH-1:0] stat
);
    logic [NUM_CH-1:0] qual;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dfg_qual_filter #(.THRESH(THRESH)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .raw     (raw[g]),
            .restart (clr),
            .qual    (qual[g])
        );
    end

    // Sticky status: set by a qualified flag, cleared only by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (clr) begin
            stat <= '0;
        end else begin
            stat <= stat | qual;
        end
    end
endmodule

// File: rtl/dfg_chip_mon.sv
// Chip-level fault qualifiers: supply over/undervoltage, temperature
// warning and thermal shutdown, each with its own filter time.
// Produces the latched flags, the live supply-fault qualifier, and a hold
// that keeps the shutdown active until the raw thermal flag has fallen.
module dfg_chip_mon
    import dfg_pkg::*;
#(
    parameter int unsigned SUP_TICKS = 10,
    parameter int unsigned TW_TICKS  = 500,
    parameter int unsigned TSD_TICKS = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  chip_flags_t raw,
    input  logic        clr,
    output chip_flags_t stat,
    output logic        sup_live,
    output logic        tsd_hold
);
    logic q_ov, q_uv, q_tw, q_tsd;
    chip_flags_t q_all;

    dfg_qual_filter #(.THRESH(SUP_TICKS)) u_ov (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw.ov), .restart(clr), .qual(q_ov));
    dfg_qual_filter #(.THRESH(SUP_TICKS)) u_uv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw.uv), .restart(clr), .qual(q_uv));
    dfg_qual_filter #(.THRESH(TW_TICKS)) u_tw (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw.tw), .restart(clr), .qual(q_tw));
    dfg_qual_filter #(.THRESH(TSD_TICKS)) u_tsd (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw.tsd), .restart(clr), .qual(q_tsd));

    // Pack the qualifier outputs into the shared flag type.
    always_comb begin
        q_all.ov  = q_ov;
        q_all.uv  = q_uv;
        q_all.tw  = q_tw;
        q_all.tsd = q_tsd;
    end

    // Sticky chip flags, cleared only by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (clr) begin
            stat <= '0;
        end else begin
            stat <= stat | q_all;
        end
    end

    // Shutdown hold: armed on qualification, released once the raw flag is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsd_hold <= 1'b0;
        end else begin
            tsd_hold <= raw.tsd && (tsd_hold || q_tsd);
        end
    end

    assign sup_live = q_ov || q_uv;
endmodule

// File: rtl/dfg_en_gate.sv
// Driver enable mask. A channel is off when its overcurrent bit is set.
// All channels are off during thermal shutdown (flag or hold) and during a
// supply fault: the live qualifier always counts, and with lockout high the
// latched supply flags count as well.
module dfg_en_gate
    import dfg_pkg::*;
#(
    parameter int unsigned NUM_CH = 11
) (
    input  logic [NUM_CH-1:0] oc_stat,
    input  chip_flags_t       chip_stat,
    input  logic              sup_live,
    input  logic              tsd_hold,
    input  logic              lockout,
    output logic [NUM_CH-1:0] drv_en
);
    logic sup_off;
    logic all_off;

    // Combine the global shutdown causes and mask the per-channel faults.
    always_comb begin
        sup_off = sup_live || (lockout && (chip_stat.ov || chip_stat.uv));
        all_off = chip_stat.tsd || tsd_hold || sup_off;
        drv_en  = all_off ? '0 : ~oc_stat;
    end
endmodule

// File: rtl/drv_fault_guard.sv
// Top of the driver fault filter and latch. Filters the per-channel
// overcurrent and open-load flags and the chip-level flags, keeps the
// sticky status words (channels at bits 1..NUM_CH), and drives the
// per-channel enable mask. Assumes every raw flag is already synchronous
// to clk.
module drv_fault_guard
    import dfg_pkg::*;
#(
    parameter int unsigned NUM_CH    = 11,
    parameter int unsigned OC_TICKS  = 10,
    parameter int unsigned OL_TICKS  = 500,
    parameter int unsigned SUP_TICKS = 10,
    parameter int unsigned TW_TICKS  = 500,
    parameter int unsigned TSD_TICKS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] oc_raw,
    input  logic [NUM_CH-1:0] ol_raw,
    input  logic              ov_raw,
    input  logic              uv_raw,
    input  logic              tw_raw,
    input  logic              tsd_raw,
    input  logic              lockout,
    input  logic              clr,
    output logic [NUM_CH:0]   stat_oc,
    output logic [NUM_CH:0]   stat_ol,
    output logic              tw_flag,
    output logic              tsd_flag,
    output logic              ov_flag,
    output logic              uv_flag,
    output logic [NUM_CH-1:0] drv_en
);
    logic [NUM_CH-1:0] oc_bits;
    logic [NUM_CH-1:0] ol_bits;
    chip_flags_t       chip_raw;
    chip_flags_t       chip_stat;
    logic              sup_live;
    logic              tsd_hold;

    // Gather the chip-level raw flags into the shared type.
    always_comb begin
        chip_raw.ov  = ov_raw;
        chip_raw.uv  = uv_raw;
        chip_raw.tw  = tw_raw;
        chip_raw.tsd = tsd_raw;
    end

    dfg_chan_bank #(.NUM_CH(NUM_CH), .THRESH(OC_TICKS)) u_oc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(oc_raw), .clr(clr), .stat(oc_bits));

    dfg_chan_bank #(.NUM_CH(NUM_CH), .THRESH(OL_TICKS)) u_ol (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ol_raw), .clr(clr), .stat(ol_bits));

    dfg_chip_mon #(.SUP_TICKS(SUP_TICKS), .TW_TICKS(TW_TICKS), .TSD_TICKS(TSD_TICKS)) u_chip (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(chip_raw), .clr(clr),
        .stat(chip_stat), .sup_live(sup_live), .tsd_hold(tsd_hold));

    dfg_en_gate #(.NUM_CH(NUM_CH)) u_gate (
        .oc_stat(oc_bits), .chip_stat(chip_stat), .sup_live(sup_live),
        .tsd_hold(tsd_hold), .lockout(lockout), .drv_en(drv_en));

    assign stat_oc  = {oc_bits, 1'b0};
    assign stat_ol  = {ol_bits, 1'b0};
    assign tw_flag  = chip_stat.tw;
    assign tsd_flag = chip_stat.tsd;
    assign ov_flag  = chip_stat.ov;
    assign uv_flag  = chip_stat.uv;
endmodule

// File: rtl/dfg_checker.sv
// Property checker for drv_fault_guard, attached through bind.
module dfg_checker #(
    parameter int unsigned NUM_CH = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              lockout,
    input logic [NUM_CH-1:0] oc_raw,
    input logic [NUM_CH:0]   stat_oc,
    input logic [NUM_CH:0]   stat_ol,
    input logic              tw_flag,
    input logic              tsd_flag,
    input logic              ov_flag,
    input logic              uv_flag,
    input logic [NUM_CH-1:0] drv_en
);
    AST_OC_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oc[NUM_CH:1] & ~$past(stat_oc[NUM_CH:1]) & ~$past(oc_raw)) == '0); // R1

    AST_OC_CUTS_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oc[NUM_CH:1] & drv_en) == '0); // R5

    AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(stat_oc) & ~stat_oc) == '0)); // R5

    AST_TSD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_flag |-> (drv_en == '0)); // R7

    AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && (ov_flag || uv_flag)) |-> (drv_en == '0)); // R9

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((stat_oc == '0) && (stat_ol == '0) && !tw_flag && !tsd_flag
                 && !ov_flag && !uv_flag)); // R10
endmodule

bind drv_fault_guard dfg_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lockout(lockout), .oc_raw(oc_raw),
    .stat_oc(stat_oc), .stat_ol(stat_ol), .tw_flag(tw_flag), .tsd_flag(tsd_flag),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .drv_en(drv_en));

// File: tb/sim_drv_fault_guard.sv
module sim_drv_fault_guard;
    localparam int N   = 11;
    localparam int OC  = 3;
    localparam int OL  = 6;
    localparam int SUP = 5;
    localparam int TW  = 4;
    localparam int TSD = 4;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic clk = 1'b0;
    logic rst_n, tick, ov_raw, uv_raw, tw_raw, tsd_raw, lockout, clr;
    logic [N-1:0] oc_raw, ol_raw, drv_en;
    logic [N:0]   stat_oc, stat_ol;
    logic tw_flag, tsd_flag, ov_flag, uv_flag;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    drv_fault_guard #(.NUM_CH(N), .OC_TICKS(OC), .OL_TICKS(OL), .SUP_TICKS(SUP),
                      .TW_TICKS(TW), .TSD_TICKS(TSD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .oc_raw(oc_raw), .ol_raw(ol_raw),
        .ov_raw(ov_raw), .uv_raw(uv_raw), .tw_raw(tw_raw), .tsd_raw(tsd_raw),
        .lockout(lockout), .clr(clr), .stat_oc(stat_oc), .stat_ol(stat_ol),
        .tw_flag(tw_flag), .tsd_flag(tsd_flag), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .drv_en(drv_en));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n rising edges and settle 1 ns after the last one.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        step(1);
        clr = 1'b0;
    endtask

    task automatic clean();
        oc_raw = '0; ol_raw = '0; ov_raw = 0; uv_raw = 0; tw_raw = 0; tsd_raw = 0;
        pulse_clr();
        step(1);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 1; oc_raw = '0; ol_raw = '0; ov_raw = 0; uv_raw = 0;
        tw_raw = 0; tsd_raw = 0; lockout = 0; clr = 0;
        step(3);
        rst_n = 1;
        step(1);
        // R12 reset state
        check("R12 stat_oc", 32'(stat_oc), 0);
        check("R12 stat_ol", 32'(stat_ol), 0);
        check("R12 flags", {28'd0, tw_flag, tsd_flag, ov_flag, uv_flag}, 0);
        check("R12 drv_en", 32'(drv_en), 32'(ALL));

        // R1 sweep of the overcurrent hold length across the threshold
        for (int n = 0; n <= OC + 2; n++) begin
            automatic int ch = (n * 3) % N;
            oc_raw[ch] = 1'b1;
            step(n);
            check("R1 oc hold sweep", 32'(stat_oc), (n >= OC + 1) ? (32'd1 << (ch + 1)) : 0);
            clean();
        end

        // R2 sweep of the open-load hold length across the threshold
        for (int n = 0; n <= OL + 2; n++) begin
            automatic int ch = (n * 5) % N;
            ol_raw[ch] = 1'b1;
            step(n);
            check("R2 ol hold sweep", 32'(stat_ol), (n >= OL + 1) ? (32'd1 << (ch + 1)) : 0);
            clean();
        end

        // R3 a gap before qualification restarts the interval
        oc_raw[1] = 1; step(OC);
        oc_raw[1] = 0; step(1);
        oc_raw[1] = 1; step(OC);
        check("R3 no set after gap", 32'(stat_oc), 0);
        step(1);
        check("R3 set after full interval", 32'(stat_oc), 32'd1 << 2);
        clean();

        // R5 / R4 per-channel cut-off, stickiness and restore
        for (int ch = 0; ch < N; ch++) begin
            oc_raw[ch] = 1; step(OC + 1);
            check("R5 oc bit", 32'(stat_oc), 32'd1 << (ch + 1));
            check("R5 only channel off", 32'(drv_en), 32'(ALL & ~(N'(1) << ch)));
            oc_raw[ch] = 0; step(2);
            check("R5 stays off after raw drop", 32'(drv_en), 32'(ALL & ~(N'(1) << ch)));
            check("R4 bit0 oc", 32'(stat_oc[0]), 0);
            pulse_clr();
            check("R5 restored by clr", 32'(drv_en), 32'(ALL));
        end

        // R6 / R4 open load and warning are report-only
        ol_raw = ALL; tw_raw = 1; step(OL + 2);
        check("R6 ol bits", 32'(stat_ol), 32'({ALL, 1'b0}));
        check("R4 bit0 ol", 32'(stat_ol[0]), 0);
        check("R6 tw flag", 32'(tw_flag), 1);
        check("R6 drv_en untouched", 32'(drv_en), 32'(ALL));
        clean();

        // R7 thermal shutdown
        tsd_raw = 1; step(TSD);
        check("R7 not yet", {31'd0, tsd_flag}, 0);
        check("R7 en before qual", 32'(drv_en), 32'(ALL));
        step(1);
        check("R7 flag set", {31'd0, tsd_flag}, 1);
        check("R7 all off", 32'(drv_en), 0);
        tsd_raw = 0; step(3);
        check("R7 off until clr", 32'(drv_en), 0);
        pulse_clr();
        check("R7 back after clr", 32'(drv_en), 32'(ALL));
        tsd_raw = 1; step(TSD + 1);
        pulse_clr();
        check("R7 flag cleared", {31'd0, tsd_flag}, 0);
        check("R7 held off while raw high", 32'(drv_en), 0);
        step(1);
        check("R7 still held", 32'(drv_en), 0);
        tsd_raw = 0; step(1);
        check("R7 on once raw low and cleared", 32'(drv_en), 32'(ALL));
        clean();

        // R8 supply fault, automatic recovery
        lockout = 0;
        ov_raw = 1; step(SUP - 1);
        check("R8 ov before qual", 32'(drv_en), 32'(ALL));
        step(1);
        check("R8 ov all off", 32'(drv_en), 0);
        step(1);
        check("R8 ov flag", {31'd0, ov_flag}, 1);
        ov_raw = 0; step(1);
        check("R8 ov auto recover", 32'(drv_en), 32'(ALL));
        check("R8 ov flag kept", {31'd0, ov_flag}, 1);
        clean();
        uv_raw = 1; step(SUP + 1);
        check("R8 uv all off", 32'(drv_en), 0);
        check("R8 uv flag", {31'd0, uv_flag}, 1);
        uv_raw = 0; step(1);
        check("R8 uv auto recover", 32'(drv_en), 32'(ALL));
        clean();

        // R9 supply fault with lockout
        lockout = 1;
        uv_raw = 1; step(SUP + 1);
        check("R9 uv flag", {31'd0, uv_flag}, 1);
        uv_raw = 0; step(3);
        check("R9 held off", 32'(drv_en), 0);
        pulse_clr();
        check("R9 clr restores", 32'(drv_en), 32'(ALL));
        lockout = 0;
        clean();

        // R10 clear restarts a still-present condition
        oc_raw[2] = 1; step(OC + 1);
        check("R10 set before clr", 32'(stat_oc), 32'd1 << 3);
        pulse_clr();
        check("R10 cleared", 32'(stat_oc), 0);
        step(OC);
        check("R10 no early reset", 32'(stat_oc), 0);
        step(1);
        check("R10 reset after fresh interval", 32'(stat_oc), 32'd1 << 3);
        clean();
        ol_raw[5] = 1; tw_raw = 1; ov_raw = 1; step(OL + 2);
        ol_raw = '0; tw_raw = 0; ov_raw = 0;
        pulse_clr();
        check("R10 all cleared", {stat_ol, tw_flag, ov_flag}, 0);

        // R11 counting only on ticks
        tick = 0; oc_raw[4] = 1; step(20);
        check("R11 no count without tick", 32'(stat_oc), 0);
        for (int i = 0; i < OC - 1; i++) begin
            tick = 1; step(1);
            tick = 0; step(1);
        end
        check("R11 short of ticks", 32'(stat_oc), 0);
        tick = 1; step(1);
        tick = 0;
        check("R11 qual edge not yet latched", 32'(stat_oc), 0);
        step(1);
        check("R11 latched without tick", 32'(stat_oc), 32'd1 << 5);
        tick = 1;
        clean();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule